// File: doc/BRIEF.md
# Control Channel Output Serializer

This block drives a single serial control line at the bit rate of the switch's transmit streams. Each frame holds 256 bit times: 32 channel slots of eight bits each. Every bit carries the control flag of one pair of output stream and channel. The flag is bit 1 of that pair's per-channel control word. Within each slot the eight bit times walk through the output streams in ascending order, starting with stream 0. The line runs one whole channel slot ahead of the transmit streams it describes, so external logic has a slot of warning before the channel it acts on goes out.

The block counts bit times from a frame pulse and keeps counting from then on without needing another pulse. A later pulse realigns the count. Once per slot it reads one word from the control memory through a combinational read port. That word holds the eight per-stream flags of one channel, indexed by stream. The block then shifts the word out over the next slot. The line is always driven and is never placed in high impedance. It stays low from reset until the first frame pulse.

Top module: `ccoSerializer`

## Requirements
- R1: After reset and until the first frame pulse, `ccoOut` is low and `rdEn` is low, whatever the control memory holds.
- R2: The frame pulse is high during the bit time just before bit 0 of a frame. During bit k (k = 0..7, earliest first) of transmit slot c, `ccoOut` equals `rdData[k]` as returned for address (c+1) mod 32. Bit k of the read word is the flag of stream k.
- R3: During the last slot (c = 31) of a frame, `ccoOut` carries the channel 0 flags that belong to the next frame.
- R4: `rdEn` is high with `rdAddr` = 1 during the frame pulse cycle. After that it is high only in bit 7 of each slot c, with `rdAddr` = (c+2) mod 32. In every other cycle it is low, so there is exactly one read per slot.
- R5: A frame pulse that arrives in the middle of a frame restarts the count. The bit time that follows the pulse is bit 0 of slot 0.
- R6: `rdData` is sampled only in a cycle where `rdEn` is high. A change to the memory during a slot has no effect on the bits of that slot that are still to be sent.
- R7: Without further frame pulses, the 256-bit sequence repeats frame after frame with the same alignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock, one cycle per serial bit |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | High for one cycle, in the bit time before frame bit 0 |
| rdEn | output | 1 | Control memory read strobe, once per slot |
| rdAddr | output | 5 | Channel whose eight stream flags are read |
| rdData | input | 8 | Flag bit of each stream for `rdAddr`, stream 0 in bit 0 |
| ccoOut | output | 1 | Serial control output |

## Verification
The memory model is filled with four patterns: all zero, all one, a checkerboard over channel plus stream, and a modular hash. With uniform patterns a stuck output or a missing load shows up. The checkerboard exposes swapped stream order and an off-by-one in the shift. The hash tells apart a one-channel lead from a zero-slot or two-slot lead, and it catches a wrong wrap at slot 31. Free-running frames, a pulse in the middle of a frame, and a memory write in the middle of a slot check realignment, flywheel counting, and that data is captured only at the fetch.

// File: rtl/ccoSerPkg.sv
package ccoSerPkg;
  // strobes from sequencing control to the shifting datapath
  typedef struct packed {
    logic load;   // capture a fresh per-channel flag word
    logic shift;  // advance to the next stream's flag
  } ccoStrobe_t;
endpackage

// File: rtl/ccoCtrl.sv
module ccoCtrl
  import ccoSerPkg::*;
#(
  parameter int NUM_STREAMS  = 8,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            framePulse,
  output ccoStrobe_t                      strobe,
  output logic                            rdEn,
  output logic [$clog2(NUM_CHANNELS)-1:0] rdAddr
);
  localparam int POS_W = $clog2(NUM_STREAMS);
  localparam int CH_W  = $clog2(NUM_CHANNELS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_STREAMS - 1);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CHANNELS - 1);
  localparam logic [CH_W-1:0]  FIRST_FETCH = CH_W'(1 % NUM_CHANNELS);
  localparam logic [CH_W:0]    CH_COUNT = (CH_W + 1)'(NUM_CHANNELS);

  logic [POS_W-1:0] bitPos;
  logic [CH_W-1:0]  chan;
  logic             synced;
  logic             slotEnd;
  logic [CH_W:0]    aheadSum;
  logic [CH_W-1:0]  fetchChan;

  assign slotEnd = synced && (bitPos == LAST_POS);

  // channel two slots beyond the current one, modulo the channel count
  always_comb begin
    aheadSum = {1'b0, chan} + (CH_W + 1)'(2);
    if (aheadSum >= CH_COUNT) fetchChan = CH_W'(aheadSum - CH_COUNT);
    else                      fetchChan = aheadSum[CH_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
      chan   <= '0;
      synced <= 1'b0;
    end else if (framePulse) begin
      bitPos <= '0;
      chan   <= '0;
      synced <= 1'b1;
    end else if (slotEnd) begin
      bitPos <= '0;
      chan   <= (chan == LAST_CH) ? '0 : chan + CH_W'(1);
    end else if (synced) begin
      bitPos <= bitPos + POS_W'(1);
    end
  end

  always_comb begin
    strobe.load  = framePulse || slotEnd;
    strobe.shift = synced && !strobe.load;
    rdEn         = strobe.load;
    rdAddr       = framePulse ? FIRST_FETCH : fetchChan;
  end

  // R5
  realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> (bitPos == '0 && chan == '0 && synced));

  // R4
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (!rdEn || framePulse));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotEnd && chan == LAST_CH && !framePulse) |=> (chan == '0 && bitPos == '0));
endmodule

// File: rtl/ccoShifter.sv
module ccoShifter
  import ccoSerPkg::*;
#(
  parameter int NUM_STREAMS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ccoStrobe_t             strobe,
  input  logic [NUM_STREAMS-1:0] rdData,
  output logic                   ccoOut
);
  logic [NUM_STREAMS-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= rdData;
    else if (strobe.shift) shiftReg <= shiftReg >> 1;
  end

  assign ccoOut = shiftReg[0];

  // R2
  load_first_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (ccoOut == $past(rdData[0])));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.shift) |=> $stable(ccoOut));
endmodule

// File: rtl/ccoSerializer.sv
module ccoSerializer
  import ccoSerPkg::*;
#(
  parameter int NUM_STREAMS  = 8,
  parameter int NUM_CHANNELS = 32
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            framePulse,
  output logic                            rdEn,
  output logic [$clog2(NUM_CHANNELS)-1:0] rdAddr,
  input  logic [NUM_STREAMS-1:0]          rdData,
  output logic                            ccoOut
);
  ccoStrobe_t strobe;

  ccoCtrl #(
    .NUM_STREAMS (NUM_STREAMS),
    .NUM_CHANNELS(NUM_CHANNELS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .framePulse(framePulse),
    .strobe    (strobe),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr)
  );

  ccoShifter #(
    .NUM_STREAMS(NUM_STREAMS)
  ) u_shift (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .rdData(rdData),
    .ccoOut(ccoOut)
  );

  // R4
  pulse_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |-> (rdEn && rdAddr == 1));
endmodule

// File: tb/ccoSerializer_tb.sv
module ccoSerializer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 8;
  localparam int C = 32;
  localparam int FRAME_BITS = S * C;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         framePulse = 1'b0;
  logic         rdEn;
  logic [4:0]   rdAddr;
  logic [S-1:0] rdData;
  logic         ccoOut;

  logic [S-1:0] mem    [C];
  logic [S-1:0] shadow [C];

  int testCount = 0;
  int failCount = 0;

  assign rdData = mem[rdAddr];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccoSerializer u_dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .ccoOut(ccoOut)
  );

  function automatic logic patBit(int pat, int c, int s);
    case (pat)
      0:       return 1'b0;
      1:       return 1'b1;
      2:       return 1'((c + s) & 1);
      default: return 1'(((c * 5 + s * 3) % 7) < 3);
    endcase
  endfunction

  task automatic fillMem(int pat);
    for (int c = 0; c < C; c++)
      for (int s = 0; s < S; s++) begin
        mem[c][s]    = patBit(pat, c, s);
        shadow[c][s] = patBit(pat, c, s);
      end
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at mid bit time idx of a frame (counted from the pulse)
  task automatic checkBit(int idx, string req);
    int slot = idx / S;
    int k = idx % S;
    check(req, {7'b0, ccoOut}, {7'b0, shadow[(slot + 1) % C][k]});
    if (k == S - 1) begin
      check("R4", {7'b0, rdEn}, 8'd1);
      check("R4", {3'b0, rdAddr}, 8'((slot + 2) % C));
    end else begin
      check("R4", {7'b0, rdEn}, 8'd0);
    end
  endtask

  // pulse, then check nBits bit times
  task automatic pulseRun(int nBits, string req);
    @(negedge clk);
    framePulse = 1'b1;
    #1;
    check("R4", {7'b0, rdEn}, 8'd1);
    check("R4", {3'b0, rdAddr}, 8'd1);
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk);
      framePulse = 1'b0;
      #1;
      checkBit(i % FRAME_BITS, (i % FRAME_BITS) >= FRAME_BITS - S ? "R3" :
                               (i >= FRAME_BITS) ? "R7" : req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    fillMem(1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle low before any frame pulse
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      check("R1", {7'b0, ccoOut}, 8'd0);
      check("R1", {7'b0, rdEn}, 8'd0);
    end
    // R2 R3 R7 across patterns, two free-running frames each
    for (int p = 0; p < 4; p++) begin
      fillMem(p);
      pulseRun(2 * FRAME_BITS, "R2");
    end
    // R5: mid-frame realignment
    fillMem(3);
    pulseRun(100, "R2");
    pulseRun(FRAME_BITS, "R5");
    // R6: memory change mid-slot does not disturb that slot
    fillMem(2);
    @(negedge clk);
    framePulse = 1'b1;
    for (int i = 0; i < 2 * FRAME_BITS; i++) begin
      @(negedge clk);
      framePulse = 1'b0;
      #1;
      checkBit(i % FRAME_BITS, "R6");
      if (i == 42) mem[6] = ~mem[6];      // slot 5 sends channel 6
      if (i == 48) shadow[6] = mem[6];    // takes effect next frame
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule